// File: doc/BRIEF.md
# Snooping Three-State Cache Coherence Controller

This block keeps a group of small direct-mapped, write-back caches coherent on one shared bus. Each cache serves its own processor port. Each line in a cache is in one of three states: not present, shared or exclusive. An exclusive line may also be dirty. Every cache snoops every transaction that another cache puts on the bus and adjusts its own copy. A value written by one processor therefore never survives as a stale copy somewhere else.

A processor read that hits returns data locally. A processor write to an exclusive line completes locally. Any other access needs the bus. The cache requests the bus and a round-robin arbiter grants it. The whole transaction (read, read-exclusive or write-back) then completes in the grant cycle. A write to a line that is not held exclusively is carried out as a read-exclusive followed by the local write. A cache that holds the line dirty supplies the data in place of memory and writes it to memory in the same cycle. Main memory sits outside the block behind a simple port with a combinational read and a clocked write.

Addresses are split into an index, the low `IDX_W` bits, and a tag, the remaining upper bits. Latency below is counted in rising clock edges. The first edge is the one that samples `cpu_req` high, and `cpu_done` is seen high after the Nth edge. The processor holds its request until `cpu_done` and drops it in the cycle that follows.

Top module: `coh_cluster`

## Requirements
- R1: After reset `cpu_done` and `mem_we` are low and every line of every cache is not present, so the first read of any address takes the bus path with a latency of 2.
- R2: A read miss while no other cache holds the address loads the line exclusive; a later write to it by the same cache completes with latency 1 and leaves memory unchanged.
- R3: A read miss while another cache holds the address loads it shared in both caches; a later write to it by either cache takes the bus path with latency 2.
- R4: A read hit returns the cached data with latency 1, and `cpu_done` is high for exactly one cycle per request.
- R5: A write to a line that is absent or shared issues a read-exclusive and then writes locally, with latency 2; subsequent reads from any cache return the written value.
- R6: Once a write completes, no other cache holds a valid copy of that address, so their next read misses (latency 2) and returns the new value; at no time is an address exclusive in one cache and valid in another.
- R7: A snooped read that hits a dirty exclusive line takes its data from that line; memory is updated in the same transaction; the former owner becomes shared, so its next write needs the bus (latency 2).
- R8: A snooped read-exclusive that hits a dirty exclusive line writes that line's data to memory and invalidates it; the former owner's next read misses and returns the new writer's value.
- R9: The bus is granted to at most one requesting cache per cycle by round robin: after reset cache 0 ranks first, and after a grant to cache i the search starts at cache i+1.
- R10: A miss whose index holds a dirty line of a different tag first writes the victim back to memory and then fills, with a latency of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | N_CACHE | Per-cache request, held until done |
| cpu_we | input | N_CACHE | Per-cache write (1) or read (0) |
| cpu_addr | input | N_CACHE*ADDR_W | Per-cache address, cache c at bits c*ADDR_W |
| cpu_wdata | input | N_CACHE*DATA_W | Per-cache write data |
| cpu_done | output | N_CACHE | One-cycle completion pulse per cache |
| cpu_rdata | output | N_CACHE*DATA_W | Per-cache read data, valid with done |
| mem_addr | output | ADDR_W | Memory address of the current bus transaction |
| mem_we | output | 1 | Memory write strobe (write-back or flush) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data for `mem_addr`, combinational |

## Verification
The bound checker watches every cycle for the following. The arbiter never grants more than one cache, and never grants a cache that is not requesting. At most one cache supplies dirty data in any transaction. Memory is written only while a transaction holds the bus. Completion pulses never last two cycles. No address is ever exclusive in one cache while valid in another.

Only the directed scenarios can show the rest. They show which state a line was loaded in, and they reveal it through the latency of later accesses. They show that snooped traffic delivers the newest value and updates memory at the right moment. They show that victims are written back before a fill, and that grant order rotates between simultaneous misses.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHD = 2'd1,
    ST_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_RD   = 2'd1,
    BOP_RDX  = 2'd2,
    BOP_WB   = 2'd3
  } bus_op_t;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int N_REQ = 3,
  localparam int CW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt,
  output logic             gnt_valid,
  output logic [CW-1:0]    gnt_idx
);
  logic [CW-1:0] last_q;

  always_comb begin
    gnt       = '0;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      int c;
      c = (int'(last_q) + k) % N_REQ;
      if (!gnt_valid && req[c]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CW'(c);
        gnt[c]    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= CW'(N_REQ - 1);
    else if (gnt_valid) last_q <= gnt_idx;
  end
endmodule

// File: rtl/coh_cache_ctl.sv
module coh_cache_ctl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic                   cpu_done,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   bus_req,
  output bus_op_t                bus_op_o,
  output logic [ADDR_W-1:0]      bus_addr_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  input  logic                   bus_active,
  input  logic                   bus_gnt,
  input  bus_op_t                bus_op_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DATA_W-1:0]      bus_data_i,
  input  logic                   bus_shared_i,
  output logic                   snp_shared,
  output logic                   snp_flush,
  output logic [DATA_W-1:0]      snp_data,
  output logic [LINES*2-1:0]     line_st_o,
  output logic [LINES*TAG_W-1:0] line_tag_o
);
  typedef enum logic [1:0] {F_IDLE, F_MISS, F_ACK} fsm_t;

  logic [DATA_W-1:0] dat_q [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  line_st_t          st_q  [LINES];
  logic              drt_q [LINES];
  fsm_t              fsm_q;

  // processor side lookup
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag;
  line_st_t         c_st;
  logic             c_hit, need_wb;
  assign c_idx   = cpu_addr[IDX_W-1:0];
  assign c_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign c_st    = st_q[c_idx];
  assign c_hit   = (c_st != ST_INV) && (tag_q[c_idx] == c_tag);
  assign need_wb = (c_st != ST_INV) && (tag_q[c_idx] != c_tag) && drt_q[c_idx];

  assign bus_req     = (fsm_q == F_MISS);
  assign bus_op_o    = need_wb ? BOP_WB : (cpu_we ? BOP_RDX : BOP_RD);
  assign bus_addr_o  = need_wb ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_wdata_o = dat_q[c_idx];

  // snoop side lookup
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit;
  assign s_idx = bus_addr_i[IDX_W-1:0];
  assign s_tag = bus_addr_i[ADDR_W-1:IDX_W];
  assign s_hit = bus_active && !bus_gnt && (st_q[s_idx] != ST_INV) &&
                 (tag_q[s_idx] == s_tag) &&
                 (bus_op_i == BOP_RD || bus_op_i == BOP_RDX);
  assign snp_shared = s_hit && (bus_op_i == BOP_RD);
  assign snp_flush  = s_hit && drt_q[s_idx];
  assign snp_data   = dat_q[s_idx];

  for (genvar l = 0; l < LINES; l++) begin : g_vis
    assign line_st_o[l*2 +: 2]         = st_q[l];
    assign line_tag_o[l*TAG_W +: TAG_W] = tag_q[l];
  end

  // data and tag arrays: no reset, plain indexed writes
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (fsm_q == F_IDLE && cpu_req && !bus_active && c_hit && cpu_we && c_st == ST_EXC)
        dat_q[c_idx] <= cpu_wdata;
      else if (fsm_q == F_MISS && bus_gnt && bus_op_o != BOP_WB) begin
        dat_q[c_idx] <= (bus_op_o == BOP_RDX) ? cpu_wdata : bus_data_i;
        tag_q[c_idx] <= c_tag;
      end
    end
  end

  // line state, dirty bits and control
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q     <= F_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      for (int l = 0; l < LINES; l++) begin
        st_q[l]  <= ST_INV;
        drt_q[l] <= 1'b0;
      end
    end else begin
      cpu_done <= 1'b0;
      if (s_hit) begin
        st_q[s_idx]  <= (bus_op_i == BOP_RD) ? ST_SHD : ST_INV;
        drt_q[s_idx] <= 1'b0;
      end
      case (fsm_q)
        F_IDLE: if (cpu_req && !bus_active) begin
          if (c_hit && !cpu_we) begin
            cpu_rdata <= dat_q[c_idx];
            cpu_done  <= 1'b1;
            fsm_q     <= F_ACK;
          end else if (c_hit && c_st == ST_EXC) begin
            drt_q[c_idx] <= 1'b1;
            cpu_done     <= 1'b1;
            fsm_q        <= F_ACK;
          end else begin
            fsm_q <= F_MISS;
          end
        end
        F_MISS: if (bus_gnt) begin
          case (bus_op_o)
            BOP_WB: begin
              st_q[c_idx]  <= ST_INV;
              drt_q[c_idx] <= 1'b0;
            end
            BOP_RD: begin
              st_q[c_idx]  <= bus_shared_i ? ST_SHD : ST_EXC;
              drt_q[c_idx] <= 1'b0;
              cpu_rdata    <= bus_data_i;
              cpu_done     <= 1'b1;
              fsm_q        <= F_ACK;
            end
            default: begin
              st_q[c_idx]  <= ST_EXC;
              drt_q[c_idx] <= 1'b1;
              cpu_done     <= 1'b1;
              fsm_q        <= F_ACK;
            end
          endcase
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_cluster.sv
module coh_cluster
  import coh_pkg::*;
#(
  parameter int N_CACHE = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2,
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int LINES  = 1 << IDX_W,
  localparam int CW     = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CACHE-1:0]        cpu_req,
  input  logic [N_CACHE-1:0]        cpu_we,
  input  logic [N_CACHE*ADDR_W-1:0] cpu_addr,
  input  logic [N_CACHE*DATA_W-1:0] cpu_wdata,
  output logic [N_CACHE-1:0]        cpu_done,
  output logic [N_CACHE*DATA_W-1:0] cpu_rdata,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_we,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata
);
  logic [N_CACHE-1:0]              req_vec, gnt_vec, snp_shared, snp_flush;
  bus_op_t                         cop   [N_CACHE];
  logic [ADDR_W-1:0]               caddr [N_CACHE];
  logic [DATA_W-1:0]               cwd   [N_CACHE];
  logic [DATA_W-1:0]               sdat  [N_CACHE];
  logic [N_CACHE*LINES*2-1:0]      st_all;
  logic [N_CACHE*LINES*TAG_W-1:0]  tag_all;
  logic                            gnt_valid, shared_any, flush_any;
  logic [CW-1:0]                   gnt_idx;
  bus_op_t                         bus_op;
  logic [ADDR_W-1:0]               bus_addr;
  logic [DATA_W-1:0]               bus_data, flush_data;

  coh_rr_arb #(.N_REQ(N_CACHE)) u_arb (
    .clk(clk), .rst(rst), .req(req_vec), .gnt(gnt_vec),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  assign bus_op   = gnt_valid ? cop[gnt_idx] : BOP_NONE;
  assign bus_addr = caddr[gnt_idx];

  always_comb begin
    flush_data = '0;
    for (int c = 0; c < N_CACHE; c++)
      if (snp_flush[c]) flush_data = flush_data | sdat[c];
  end

  assign shared_any = |snp_shared;
  assign flush_any  = |snp_flush;
  assign bus_data   = flush_any ? flush_data : mem_rdata;
  assign mem_addr   = bus_addr;
  assign mem_we     = gnt_valid && (bus_op == BOP_WB || flush_any);
  assign mem_wdata  = (bus_op == BOP_WB) ? cwd[gnt_idx] : flush_data;

  for (genvar c = 0; c < N_CACHE; c++) begin : g_cache
    coh_cache_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cc (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req[c]), .cpu_we(cpu_we[c]),
      .cpu_addr(cpu_addr[c*ADDR_W +: ADDR_W]),
      .cpu_wdata(cpu_wdata[c*DATA_W +: DATA_W]),
      .cpu_done(cpu_done[c]),
      .cpu_rdata(cpu_rdata[c*DATA_W +: DATA_W]),
      .bus_req(req_vec[c]), .bus_op_o(cop[c]), .bus_addr_o(caddr[c]),
      .bus_wdata_o(cwd[c]),
      .bus_active(gnt_valid), .bus_gnt(gnt_vec[c]), .bus_op_i(bus_op),
      .bus_addr_i(bus_addr), .bus_data_i(bus_data), .bus_shared_i(shared_any),
      .snp_shared(snp_shared[c]), .snp_flush(snp_flush[c]), .snp_data(sdat[c]),
      .line_st_o(st_all[c*LINES*2 +: LINES*2]),
      .line_tag_o(tag_all[c*LINES*TAG_W +: LINES*TAG_W])
    );
  end
endmodule

// File: rtl/coh_cluster_chk.sv
module coh_cluster_chk #(
  parameter int N_CACHE = 3,
  parameter int LINES   = 4,
  parameter int TAG_W   = 6
) (
  input logic                           clk,
  input logic                           rst,
  input logic [N_CACHE-1:0]             req_vec,
  input logic [N_CACHE-1:0]             gnt_vec,
  input logic [N_CACHE-1:0]             snp_flush,
  input logic [N_CACHE-1:0]             cpu_done,
  input logic                           mem_we,
  input logic [N_CACHE*LINES*2-1:0]     st_all,
  input logic [N_CACHE*LINES*TAG_W-1:0] tag_all
);
  logic own_clash;

  always_comb begin
    own_clash = 1'b0;
    for (int a = 0; a < N_CACHE; a++)
      for (int b = 0; b < N_CACHE; b++)
        for (int l = 0; l < LINES; l++)
          if (a != b && st_all[(a*LINES+l)*2 +: 2] == 2'd2 &&
              st_all[(b*LINES+l)*2 +: 2] != 2'd0 &&
              tag_all[(a*LINES+l)*TAG_W +: TAG_W] == tag_all[(b*LINES+l)*TAG_W +: TAG_W])
            own_clash = 1'b1;
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_vec));
  p_grant_has_req_r9: assert property (@(posedge clk) disable iff (rst)
    (gnt_vec & ~req_vec) == '0);
  p_single_owner_r6: assert property (@(posedge clk) disable iff (rst)
    !own_clash);
  p_one_supplier_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(snp_flush));
  p_mem_we_on_bus_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (gnt_vec != '0));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_done != '0) |=> ((cpu_done & $past(cpu_done)) == '0));
endmodule

bind coh_cluster coh_cluster_chk #(.N_CACHE(N_CACHE), .LINES(LINES), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .req_vec(req_vec), .gnt_vec(gnt_vec),
  .snp_flush(snp_flush), .cpu_done(cpu_done), .mem_we(mem_we),
  .st_all(st_all), .tag_all(tag_all)
);

// File: tb/sim_coh_cluster.sv
module sim_coh_cluster;
  localparam int N = 3, AW = 8, DW = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    cpu_req = '0, cpu_we = '0;
  logic [N*AW-1:0] cpu_addr = '0;
  logic [N*DW-1:0] cpu_wdata = '0;
  logic [N-1:0]    cpu_done;
  logic [N*DW-1:0] cpu_rdata;
  logic [AW-1:0]   mem_addr;
  logic            mem_we;
  logic [DW-1:0]   mem_wdata, mem_rdata;
  logic [DW-1:0]   mem [256];
  int              n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  coh_cluster u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cpu_req = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_op(input int c, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd, output int lat);
    cpu_we[c] = we;
    cpu_addr[c*AW +: AW] = a;
    cpu_wdata[c*DW +: DW] = d;
    cpu_req[c] = 1'b1;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lat++;
      if (cpu_done[c]) break;
    end
    rd = cpu_rdata[c*DW +: DW];
    cpu_req[c] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; int lat;
    do_reset();
    chk("R1 done after reset", 32'(cpu_done), 0);
    chk("R1 mem_we after reset", 32'(mem_we), 0);
    do_op(0, 0, 8'h10, 0, rd, lat);
    chk("R1 first read latency", lat, 2);
    chk("R1 first read data", rd, 16'hA010);
  endtask

  task automatic t_exclusive();
    logic [DW-1:0] rd; int lat;
    do_reset();
    do_op(2, 0, 8'h30, 0, rd, lat);
    chk("R2 lone read latency", lat, 2);
    chk("R2 lone read data", rd, 16'hA030);
    do_op(2, 1, 8'h30, 16'h7777, rd, lat);
    chk("R2 write on exclusive latency", lat, 1);
    chk("R2 memory untouched", mem[8'h30], 16'hA030);
    do_op(2, 0, 8'h30, 0, rd, lat);
    chk("R4 hit latency", lat, 1);
    chk("R4 hit data", rd, 16'h7777);
    chk("R4 done is a pulse", 32'(cpu_done[2]), 0);
  endtask

  task automatic t_shared();
    logic [DW-1:0] rd; int lat;
    do_reset();
    do_op(0, 0, 8'h41, 0, rd, lat);
    do_op(1, 0, 8'h41, 0, rd, lat);
    chk("R3 second reader latency", lat, 2);
    chk("R3 second reader data", rd, 16'hA041);
    do_op(0, 0, 8'h41, 0, rd, lat);
    chk("R3 first reader keeps copy", lat, 1);
    do_op(1, 1, 8'h41, 16'h8888, rd, lat);
    chk("R3 write on shared latency", lat, 2);
    do_op(0, 0, 8'h41, 0, rd, lat);
    chk("R6 invalidated reader latency", lat, 2);
    chk("R6 invalidated reader data", rd, 16'h8888);
    do_op(1, 0, 8'h41, 0, rd, lat);
    chk("R4 hit after demotion", lat, 1);
    chk("R4 hit data after demotion", rd, 16'h8888);
  endtask

  task automatic t_upgrade();
    logic [DW-1:0] rd; int lat;
    do_reset();
    do_op(0, 1, 8'h52, 16'h1234, rd, lat);
    chk("R5 write miss latency", lat, 2);
    do_op(1, 0, 8'h52, 0, rd, lat);
    chk("R5 reader sees write", rd, 16'h1234);
    do_op(2, 0, 8'h52, 0, rd, lat);
    chk("R5 second reader sees write", rd, 16'h1234);
    do_op(2, 1, 8'h52, 16'h5678, rd, lat);
    chk("R5 upgrade from shared latency", lat, 2);
    do_op(0, 0, 8'h52, 0, rd, lat);
    chk("R6 cache0 miss latency", lat, 2);
    chk("R6 cache0 new value", rd, 16'h5678);
    do_op(1, 0, 8'h52, 0, rd, lat);
    chk("R6 cache1 miss latency", lat, 2);
    chk("R6 cache1 new value", rd, 16'h5678);
  endtask

  task automatic t_snoop_read();
    logic [DW-1:0] rd; int lat;
    do_reset();
    do_op(0, 1, 8'h63, 16'h2222, rd, lat);
    chk("R7 memory stale before snoop", mem[8'h63], 16'hA063);
    do_op(1, 0, 8'h63, 0, rd, lat);
    chk("R7 supplied data", rd, 16'h2222);
    chk("R7 memory updated", mem[8'h63], 16'h2222);
    do_op(0, 1, 8'h63, 16'h3333, rd, lat);
    chk("R7 owner demoted to shared", lat, 2);
  endtask

  task automatic t_snoop_rdx();
    logic [DW-1:0] rd; int lat;
    do_reset();
    do_op(0, 1, 8'h71, 16'h5555, rd, lat);
    do_op(1, 1, 8'h71, 16'h6666, rd, lat);
    chk("R8 writer latency", lat, 2);
    chk("R8 dirty data flushed", mem[8'h71], 16'h5555);
    do_op(0, 0, 8'h71, 0, rd, lat);
    chk("R8 old owner miss latency", lat, 2);
    chk("R8 old owner new value", rd, 16'h6666);
  endtask

  task automatic t_victim();
    logic [DW-1:0] rd; int lat;
    do_reset();
    do_op(0, 1, 8'h04, 16'h1111, rd, lat);
    do_op(0, 0, 8'h08, 0, rd, lat);
    chk("R10 evict-then-fill latency", lat, 3);
    chk("R10 fill data", rd, 16'hA008);
    chk("R10 victim in memory", mem[8'h04], 16'h1111);
    do_op(0, 0, 8'h04, 0, rd, lat);
    chk("R10 victim reread", rd, 16'h1111);
  endtask

  task automatic pair(input int a, input logic [AW-1:0] aa, input int b,
                      input logic [AW-1:0] ba, output int ta, output int tb);
    cpu_we[a] = 0; cpu_we[b] = 0;
    cpu_addr[a*AW +: AW] = aa;
    cpu_addr[b*AW +: AW] = ba;
    cpu_req[a] = 1; cpu_req[b] = 1;
    ta = 0; tb = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (cpu_done[a] && ta == 0) begin ta = k; cpu_req[a] = 0; end
      if (cpu_done[b] && tb == 0) begin tb = k; cpu_req[b] = 0; end
    end
    cpu_req = '0;
  endtask

  task automatic t_arbitration();
    int ta, tb;
    do_reset();
    pair(0, 8'h85, 1, 8'h96, ta, tb);
    chk("R9 cache0 first after reset", ta, 2);
    chk("R9 cache1 second", tb, 3);
    chk("R9 cache1 data", cpu_rdata[1*DW +: DW], 16'hA096);
    pair(0, 8'hA7, 2, 8'hB8, ta, tb);
    chk("R9 cache2 ahead after rotation", tb, 2);
    chk("R9 cache0 after cache2", ta, 3);
    chk("R9 cache0 data", cpu_rdata[0 +: DW], 16'hA0A7);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 | 16'(i);
    t_reset();
    t_exclusive();
    t_shared();
    t_upgrade();
    t_snoop_read();
    t_snoop_rdx();
    t_victim();
    t_arbitration();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule